// File: doc/BRIEF.md
# Edge-Interval Bit-Check Qualifier

This block decides whether a demodulated serial stream looks like a real transmission before a receiver commits to data reception. It times the gap between consecutive transitions of the data line, counted in clock cycles, and tests every gap against a programmable lower and upper limit. Once a selected number of gaps in a row land inside the window, it reports a pass, which tells the receiver to enter receiving mode. The first gap outside the window ends the check with a fail, which tells the receiver to go back to sleep.

Line coding is assumed to put two transitions in every bit, as Manchester and bi-phase coding do, so each checked bit costs two interval tests. A 2-bit setting picks how many bits are checked. A system controller pulses the start input. The block takes a copy of the limits and the setting at that moment, holds busy high while it works, and ends with a single-cycle pass or fail pulse.

Top module: `edge_window_qualifier`

## Requirements
- R1: While reset is high and in the first cycle after it is released, pass_o, fail_o and busy_o are all low.
- R2: The setting bit_sel selects 0, 3, 6 or 9 bits for the codes 00, 01, 10 and 11. That is 0, 6, 12 or 18 interval tests. Pass is given only after exactly that many in-window intervals in a row, and a stream that ends one interval short fails.
- R3: An interval is the number of clock cycles between two consecutive transitions of data_in. It counts as in-window when lim_lo <= interval <= lim_hi, with both limits included.
- R4: An interval shorter than lim_lo ends the check with a fail pulse when that transition is evaluated, and no more transitions are needed.
- R5: When lim_hi + 1 cycles pass after the last evaluated transition with no new transition, fail pulses at once, without waiting for a later transition.
- R6: The first transition after start only starts the timing and is never tested against lim_lo. If no transition arrives within lim_hi cycles of start, fail pulses lim_hi + 1 cycles after the start edge.
- R7: With bit_sel = 00, pass_o pulses in the cycle right after start is sampled, and busy_o stays low.
- R8: pass_o and fail_o are one cycle wide and never both high. busy_o is high from the cycle after an accepted start until the result pulse, and it is low while the result pulse is shown.
- R9: A start pulse while busy is ignored. Changes to lim_lo, lim_hi and bit_sel during a check have no effect on its result or its timing.
- R10: data_in passes through a two-flop synchronizer. A pass pulse or a short-interval fail appears 3 clock cycles after the data_in change that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a check when the block is idle |
| data_in | input | 1 | Demodulated data line, asynchronous |
| lim_lo | input | CNT_W | Smallest accepted interval, in cycles |
| lim_hi | input | CNT_W | Largest accepted interval, in cycles |
| bit_sel | input | 2 | Number of bits to check: 0, 3, 6 or 9 |
| pass_o | output | 1 | One-cycle pulse: enter receiving mode |
| fail_o | output | 1 | One-cycle pulse: return to sleep |
| busy_o | output | 1 | A check is in progress |

## Verification
The case that is hardest to reach from the ports is a timeout that fires with no transition at all. The timeout can happen before the first transition or after a run of good intervals. In both cases the only stimulus is the lack of stimulus, so the fail cycle has to be predicted from the last transition through the synchronizer delay. The vector table stops toggling early and includes intervals just above the upper limit, so the bench model predicts the exact fail cycle. Another vector pulses start again mid-run and at the same moment changes the limits and the setting to values that would break the run, to show that the sampled copy is what governs the check.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } bchk_state_e;
endpackage

// File: rtl/bchk_edge_sync.sv
module bchk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  // sh[0..SYNC_STAGES-1] synchronize, sh[SYNC_STAGES] holds the previous value
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], din};
  end

  assign edge_o = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];
endmodule

// File: rtl/bchk_ivl_timer.sv
module bchk_ivl_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_o <= '0;
    else if (restart)          cnt_o <= CNT_ONE;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_ONE;
  end
endmodule

// File: rtl/bchk_ctrl.sv
module bchk_ctrl
  import bchk_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int BITS_PER_STEP = 3,
  parameter int EDGES_PER_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             restart_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o
);
  localparam int CHK_PER_STEP = BITS_PER_STEP * EDGES_PER_BIT;
  localparam int MAX_CHECKS   = 3 * CHK_PER_STEP;
  localparam int REM_W        = $clog2(MAX_CHECKS + 1);
  localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

  bchk_state_e      state_q;
  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic             too_long, too_short;

  assign too_long  = cnt_i > hi_q;
  assign too_short = edge_i && (cnt_i < lo_q);
  assign restart_o = (state_q == ST_IDLE) ? start_i : edge_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lo_q <= lo_i;
            hi_q <= hi_i;
            if (sel_i == 2'd0) begin
              pass_o <= 1'b1;
            end else begin
              rem_q   <= REM_W'(CHK_PER_STEP) * REM_W'(sel_i);
              state_q <= ST_ARM;
              busy_o  <= 1'b1;
            end
          end
        end
        ST_ARM: begin
          if (too_long) begin
            fail_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (edge_i) begin
            state_q <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (too_long || too_short) begin
            fail_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (edge_i) begin
            if (rem_q == REM_ONE) begin
              pass_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              rem_q <= rem_q - REM_ONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));
  // R8
  result_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_o || fail_o) |-> !busy_o);
  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  // R4
  fail_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> $past(busy_o));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(lo_q) && $stable(hi_q)));
  // R5
  timeout_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_i > hi_q) |=> fail_o);
endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier #(
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_PER_STEP = 3,
  parameter int EDGES_PER_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             data_in,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  input  logic [1:0]       bit_sel,
  output logic             pass_o,
  output logic             fail_o,
  output logic             busy_o
);
  logic             edge_s;
  logic             restart_s;
  logic [CNT_W-1:0] cnt_s;

  bchk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(data_in), .edge_o(edge_s)
  );

  bchk_ivl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart_s), .cnt_o(cnt_s)
  );

  bchk_ctrl #(
    .CNT_W(CNT_W), .BITS_PER_STEP(BITS_PER_STEP), .EDGES_PER_BIT(EDGES_PER_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .sel_i(bit_sel),
    .lo_i(lim_lo), .hi_i(lim_hi), .edge_i(edge_s), .cnt_i(cnt_s),
    .restart_o(restart_s), .pass_o(pass_o), .fail_o(fail_o), .busy_o(busy_o)
  );
endmodule

// File: tb/tb_edge_window_qualifier.sv
module tb_edge_window_qualifier;
  localparam int CNT_W = 16;
  localparam int D     = 2;   // cycle of the first data transition after start
  localparam int NV    = 12;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] t;
    logic [7:0] ntog;
    logic       poke;
  } vec_t;

  // sel, lo, hi, interval, transitions, poke
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd4,  8'd8,  8'd6,  8'd7,  1'b0},
    '{2'd2, 8'd4,  8'd8,  8'd4,  8'd13, 1'b0},
    '{2'd3, 8'd4,  8'd8,  8'd8,  8'd19, 1'b0},
    '{2'd1, 8'd4,  8'd8,  8'd3,  8'd7,  1'b0},
    '{2'd1, 8'd4,  8'd8,  8'd9,  8'd7,  1'b0},
    '{2'd1, 8'd4,  8'd8,  8'd6,  8'd4,  1'b0},
    '{2'd1, 8'd4,  8'd8,  8'd6,  8'd6,  1'b0},
    '{2'd0, 8'd4,  8'd8,  8'd6,  8'd0,  1'b0},
    '{2'd1, 8'd5,  8'd9,  8'd7,  8'd0,  1'b0},
    '{2'd2, 8'd4,  8'd8,  8'd6,  8'd13, 1'b1},
    '{2'd3, 8'd10, 8'd20, 8'd15, 8'd19, 1'b0},
    '{2'd2, 8'd4,  8'd8,  8'd6,  8'd12, 1'b0}
  };
  string TAGS [NV] = '{"R2", "R3", "R3", "R4", "R5", "R5",
                       "R2", "R7", "R6", "R9", "R6", "R2"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             data_in = 1'b0;
  logic [CNT_W-1:0] lim_lo = '0;
  logic [CNT_W-1:0] lim_hi = '0;
  logic [1:0]       bit_sel = 2'd0;
  logic             pass_o, fail_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  edge_window_qualifier #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .bit_sel(bit_sel),
    .pass_o(pass_o), .fail_o(fail_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model: expected result and the sample index at which it shows
  function automatic void model(input vec_t v, output bit ep, output int ec);
    int need;
    int prev;
    need = 6 * int'(v.sel);
    if (need == 0) begin ep = 1'b1; ec = 0; return; end
    if (v.ntog == 0) begin ep = 1'b0; ec = int'(v.hi) + 1; return; end
    for (int k = 1; k <= need; k++) begin
      prev = D + (k - 1) * int'(v.t);
      if (k > int'(v.ntog) - 1 || v.t > v.hi) begin
        ep = 1'b0; ec = prev + int'(v.hi) + 4; return;
      end
      if (v.t < v.lo) begin
        ep = 1'b0; ec = D + k * int'(v.t) + 3; return;
      end
    end
    ep = 1'b1;
    ec = D + need * int'(v.t) + 3;
  endfunction

  task automatic run_vec(input vec_t v, input string tag);
    bit ep;
    int ec;
    int c;
    bit got_pass, got_fail, seen, busy_bad;
    model(v, ep, ec);
    @(negedge clk);
    bit_sel = v.sel;
    lim_lo  = CNT_W'(v.lo);
    lim_hi  = CNT_W'(v.hi);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0; seen = 0; busy_bad = 0; got_pass = 0; got_fail = 0;
    while (c < 2000) begin
      if (pass_o || fail_o) begin
        got_pass = pass_o; got_fail = fail_o; seen = 1;
        if (busy_o) busy_bad = 1;
        break;
      end
      if (busy_o !== 1'b1) busy_bad = 1;
      for (int k = 0; k < int'(v.ntog); k++)
        if (c == D + k * int'(v.t)) data_in = ~data_in;
      if (v.poke && c == 4) begin
        start = 1'b1; lim_lo = CNT_W'(1); lim_hi = CNT_W'(2); bit_sel = 2'd0;
      end
      if (v.poke && c == 5) start = 1'b0;
      @(negedge clk);
      c++;
    end
    // result kind (R2..R7 depending on vector)
    chk(seen && got_pass == ep && got_fail == !ep, tag,
        {got_fail, got_pass}, {!ep, ep});
    // R10 timing through the synchronizer and timer
    chk(c == ec, {tag, " R10 cycle"}, c, ec);
    // R8 busy during the check, low with the result
    chk(!busy_bad, "R8 busy", busy_bad, 0);
    @(negedge clk);
    // R8 single-cycle pulse
    chk(!pass_o && !fail_o && !busy_o, "R8 pulse", {pass_o, fail_o, busy_o}, 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs low in reset
    chk(!pass_o && !fail_o && !busy_o, "R1 in reset", {pass_o, fail_o, busy_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pass_o && !fail_o && !busy_o, "R1 after release", {pass_o, fail_o, busy_o}, 0);
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], TAGS[i]);

    // R1 reset in mid-check clears all outputs
    bit_sel = 2'd3; lim_lo = CNT_W'(4); lim_hi = CNT_W'(8); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b1, "R8 busy mid-check", busy_o, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!pass_o && !fail_o && !busy_o, "R1 mid-check reset", {pass_o, fail_o, busy_o}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(!pass_o && !fail_o && !busy_o, "R1 stays idle", {pass_o, fail_o, busy_o}, 0);

    // R7 zero-bit setting still works right after reset
    run_vec('{2'd0, 8'd4, 8'd8, 8'd6, 8'd0, 1'b0}, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule